// File: doc/BRIEF.md
# Packed Instruction Word Issue Decoder

This block sits between instruction fetch and a single execute stage. Each accepted 32-bit fetch word holds either one long operation of 30 bits or a pair of 15-bit short operations. The decoder works out the word's format, looks each operation up in a small programmable match table, and hands the resulting operations to the execute stage one per cycle. Every operation carries a tag that tells the execute stage how it was issued.

The execute stage answers during the cycle of the first operation of a pair. It reports whether that operation redirected the PC, raised an exception, or, for a condition-test operation, produced a true result. The decoder uses that answer to decide whether the partner operation is issued. A bank of free-running statistics counters records formats, suppressions, condition outcomes and illegal operations. The word input is blocked while a word is still being issued.

Top module: `issue_decoder`

## Requirements
- R1: Bits 31:30 select the format. 00 is one long op in bits 29:0. 01 is a sequential pair with the right op first. 10 is a sequential pair with the left op first. 11 is a parallel pair. The left short op is bits 29:15 and the right short op is bits 14:0, and each short op is presented zero-extended on `slot_insn`. Tags: 1 long, 2 sequential left, 3 sequential right, 4 parallel left, 5 parallel right, 6 condition test, 7 conditional execute. `slot_right` is 1 when the presented op came from bits 14:0.
- R2: A table row is selected by op bits 29:24 for a long op and by bits 14:9 for a short op. The op matches only when the row is valid, the row's long flag equals the op's size, and (op AND row mask) equals the row opcode.
- R3: An op with no match is presented with `slot_illegal`=1, its partner is never issued, and `cnt_illegal` counts each such presented op.
- R4: For a sequential pair, the feedback sampled in the first op's cycle decides what happens next. The second op is issued only if `ex_pc_changed`, `ex_exception` and the first op's illegal flag are all 0. When the PC changed with no exception and no illegal flag, `cnt_br_skip` increments.
- R5: For a parallel pair without a condition-test op, the left op is issued first (tag 4) and the right op follows (tag 5) unless the left op raised an exception or was illegal. `ex_pc_changed` has no effect in this mode.
- R6: In a parallel pair, a matching op whose row has the condition flag set is issued first with tag 6. The left op wins when both halves qualify. If no exception is raised, the partner follows with tag 7 when `ex_cond_true`=1 and `cnt_cond_true` increments; otherwise the partner is dropped and `cnt_cond_false` increments.
- R7: `cnt_cycles` increments once per accepted word and once more for every sequential second op that is issued.
- R8: `word_ready` is 0 from acceptance until the last op of the word has been issued or dropped. A `word_valid` pulse while `word_ready`=0 is ignored.
- R9: `cnt_long`, `cnt_seq_rl`, `cnt_seq_lr` and `cnt_par` count accepted words of formats 00, 01, 10 and 11.
- R10: After reset all counters are 0, `slot_valid` is 0, `word_ready` is 1 and every table row is invalid, so every op is illegal.
- R11: The first op appears on the slot outputs in the cycle after acceptance, and the second op, if issued, appears in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr_en | input | 1 | Write one match-table row |
| tbl_wr_idx | input | 6 | Row to write |
| tbl_wr_valid | input | 1 | Row holds an entry |
| tbl_wr_long | input | 1 | Row matches long ops |
| tbl_wr_cond | input | 1 | Row marks a condition-test op |
| tbl_wr_mask | input | 30 | Match mask |
| tbl_wr_opcode | input | 30 | Match value after masking |
| word_valid | input | 1 | Fetch word offered |
| word_data | input | 32 | Fetch word |
| word_ready | output | 1 | Decoder idle, word accepted when valid |
| ex_pc_changed | input | 1 | Current op redirected the PC |
| ex_exception | input | 1 | Current op raised an exception |
| ex_cond_true | input | 1 | Condition-test result of current op |
| slot_valid | output | 1 | An op is presented |
| slot_insn | output | 30 | Presented op |
| slot_tag | output | 3 | Issue tag (R1) |
| slot_right | output | 1 | Op came from bits 14:0 |
| slot_illegal | output | 1 | Op has no table match |
| cnt_cycles | output | 32 | Issue cycle count |
| cnt_long | output | 32 | Long words |
| cnt_seq_lr | output | 32 | Left-first sequential words |
| cnt_seq_rl | output | 32 | Right-first sequential words |
| cnt_par | output | 32 | Parallel words |
| cnt_cond_true | output | 32 | Conditional partners executed |
| cnt_cond_false | output | 32 | Conditional partners dropped |
| cnt_br_skip | output | 32 | Second ops dropped by a PC change |
| cnt_illegal | output | 32 | Illegal ops presented |

## Verification
The properties assume that the execute stage answers in the same cycle as the presented op, and that `ex_exception` refers only to the op on the slot outputs. The ordering properties also assume the table is not rewritten while a word is in flight. The stimulus holds all three feedback lines constant from acceptance until the word drains. It writes the table only while the decoder is idle, and it offers new words only when `word_ready` is high, except for one deliberate pulse during a busy cycle.

// File: rtl/issue_pkg.sv
package issue_pkg;

    parameter int WORD_W        = 32;
    parameter int SHORT_W       = 15;
    parameter int LONG_W        = 2 * SHORT_W;
    parameter int IDX_W         = 6;
    parameter int LONG_IDX_LSB  = 24;
    parameter int SHORT_IDX_LSB = 9;
    parameter int TAG_W         = 3;

    localparam int ST_CYCLES = 0;
    localparam int ST_LONG   = 1;
    localparam int ST_LR     = 2;
    localparam int ST_RL     = 3;
    localparam int ST_PAR    = 4;
    localparam int ST_CTRUE  = 5;
    localparam int ST_CFALSE = 6;
    localparam int ST_BRSKIP = 7;
    localparam int ST_ILL    = 8;
    localparam int ST_NUM    = 9;

    typedef enum logic [TAG_W-1:0] {
        TAG_NONE  = 3'd0,
        TAG_LONG  = 3'd1,
        TAG_LEFT  = 3'd2,
        TAG_RIGHT = 3'd3,
        TAG_PAR_L = 3'd4,
        TAG_PAR_R = 3'd5,
        TAG_CTEST = 3'd6,
        TAG_CEXE  = 3'd7
    } slot_tag_e;

    // format encodings are decoded from the word, so their values matter
    typedef enum logic [1:0] {
        FMT_LONG   = 2'b00,
        FMT_RFIRST = 2'b01,
        FMT_LFIRST = 2'b10,
        FMT_PAR    = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        MODE_LONG,
        MODE_SEQ,
        MODE_PAR,
        MODE_COND
    } issue_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_FIRST,
        PH_SECOND
    } phase_e;

    typedef struct packed {
        logic              valid;
        logic              is_long;
        logic              cond_only;
        logic [LONG_W-1:0] mask;
        logic [LONG_W-1:0] opcode;
    } opc_entry_t;

    typedef struct packed {
        logic [LONG_W-1:0] op;
        logic              is_long;
    } lookup_req_t;

    typedef struct packed {
        logic hit;
        logic cond_only;
    } lookup_rsp_t;

    typedef struct packed {
        logic [LONG_W-1:0] op;
        slot_tag_e         tag;
        logic              right;
        logic              illegal;
    } slot_t;

endpackage

// File: rtl/opc_table.sv
module opc_table
    import issue_pkg::*;
#(
    parameter int NPORT = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  opc_entry_t             wr_entry,
    input  lookup_req_t [NPORT-1:0] req,
    output lookup_rsp_t [NPORT-1:0] rsp
);

    localparam int ROWS = 1 << IDX_W;

    opc_entry_t rows_q [ROWS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ROWS; i++) begin
                rows_q[i] <= '0;
            end
        end else if (wr_en) begin
            rows_q[wr_idx] <= wr_entry;
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic [IDX_W-1:0] idx;
        opc_entry_t       ent;
        lookup_rsp_t      res;

        always_comb begin
            if (req[p].is_long) begin
                idx = req[p].op[LONG_IDX_LSB +: IDX_W];
            end else begin
                idx = req[p].op[SHORT_IDX_LSB +: IDX_W];
            end
            ent           = rows_q[idx];
            res.hit       = ent.valid
                          && (ent.is_long == req[p].is_long)
                          && ((req[p].op & ent.mask) == ent.opcode);
            res.cond_only = ent.cond_only;
        end

        assign rsp[p] = res;
    end

endmodule

// File: rtl/word_split.sv
module word_split
    import issue_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  lookup_rsp_t       rsp_l,
    input  lookup_rsp_t       rsp_r,
    output lookup_req_t       req_l,
    output lookup_req_t       req_r,
    output issue_mode_e       mode,
    output slot_t             first,
    output slot_t             second
);

    localparam int PAD_W = LONG_W - SHORT_W;

    fmt_e              fmt;
    logic [LONG_W-1:0] left_op;
    logic [LONG_W-1:0] right_op;
    logic [LONG_W-1:0] long_op;

    assign fmt      = fmt_e'(word[WORD_W-1 -: 2]);
    assign long_op  = word[LONG_W-1:0];
    assign left_op  = {{PAD_W{1'b0}}, word[LONG_W-1:SHORT_W]};
    assign right_op = {{PAD_W{1'b0}}, word[SHORT_W-1:0]};

    always_comb begin
        req_l.is_long = (fmt == FMT_LONG);
        req_l.op      = (fmt == FMT_LONG) ? long_op : left_op;
        req_r.is_long = 1'b0;
        req_r.op      = right_op;
    end

    // build one slot from a half of the word
    function automatic slot_t make_slot(logic [LONG_W-1:0] op, slot_tag_e tag,
                                        logic right, logic hit);
        slot_t s;
        s.op      = op;
        s.tag     = tag;
        s.right   = right;
        s.illegal = !hit;
        return s;
    endfunction

    always_comb begin
        mode   = MODE_LONG;
        first  = '0;
        second = '0;
        unique case (fmt)
            FMT_LONG: begin
                mode  = MODE_LONG;
                first = make_slot(long_op, TAG_LONG, 1'b0, rsp_l.hit);
            end
            FMT_RFIRST: begin
                mode   = MODE_SEQ;
                first  = make_slot(right_op, TAG_RIGHT, 1'b1, rsp_r.hit);
                second = make_slot(left_op, TAG_LEFT, 1'b0, rsp_l.hit);
            end
            FMT_LFIRST: begin
                mode   = MODE_SEQ;
                first  = make_slot(left_op, TAG_LEFT, 1'b0, rsp_l.hit);
                second = make_slot(right_op, TAG_RIGHT, 1'b1, rsp_r.hit);
            end
            FMT_PAR: begin
                if (rsp_l.hit && rsp_l.cond_only) begin
                    mode   = MODE_COND;
                    first  = make_slot(left_op, TAG_CTEST, 1'b0, rsp_l.hit);
                    second = make_slot(right_op, TAG_CEXE, 1'b1, rsp_r.hit);
                end else if (rsp_r.hit && rsp_r.cond_only) begin
                    mode   = MODE_COND;
                    first  = make_slot(right_op, TAG_CTEST, 1'b1, rsp_r.hit);
                    second = make_slot(left_op, TAG_CEXE, 1'b0, rsp_l.hit);
                end else begin
                    mode   = MODE_PAR;
                    first  = make_slot(left_op, TAG_PAR_L, 1'b0, rsp_l.hit);
                    second = make_slot(right_op, TAG_PAR_R, 1'b1, rsp_r.hit);
                end
            end
            default: begin
                mode = MODE_LONG;
            end
        endcase
    end

endmodule

// File: rtl/stat_bank.sv
module stat_bank #(
    parameter int NUM = 9,
    parameter int W   = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM-1:0]        inc,
    output logic [NUM-1:0][W-1:0] cnt
);

    for (genvar k = 0; k < NUM; k++) begin : g_cnt
        logic [W-1:0] val_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (inc[k]) begin
                val_q <= val_q + W'(1);
            end
        end

        assign cnt[k] = val_q;
    end

endmodule

// File: rtl/issue_decoder.sv
module issue_decoder
    import issue_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tbl_wr_en,
    input  logic [IDX_W-1:0]   tbl_wr_idx,
    input  logic               tbl_wr_valid,
    input  logic               tbl_wr_long,
    input  logic               tbl_wr_cond,
    input  logic [LONG_W-1:0]  tbl_wr_mask,
    input  logic [LONG_W-1:0]  tbl_wr_opcode,
    input  logic               word_valid,
    input  logic [WORD_W-1:0]  word_data,
    output logic               word_ready,
    input  logic               ex_pc_changed,
    input  logic               ex_exception,
    input  logic               ex_cond_true,
    output logic               slot_valid,
    output logic [LONG_W-1:0]  slot_insn,
    output logic [TAG_W-1:0]   slot_tag,
    output logic               slot_right,
    output logic               slot_illegal,
    output logic [CNT_W-1:0]   cnt_cycles,
    output logic [CNT_W-1:0]   cnt_long,
    output logic [CNT_W-1:0]   cnt_seq_lr,
    output logic [CNT_W-1:0]   cnt_seq_rl,
    output logic [CNT_W-1:0]   cnt_par,
    output logic [CNT_W-1:0]   cnt_cond_true,
    output logic [CNT_W-1:0]   cnt_cond_false,
    output logic [CNT_W-1:0]   cnt_br_skip,
    output logic [CNT_W-1:0]   cnt_illegal
);

    localparam int NPORT = 2;

    typedef struct packed {
        phase_e            phase;
        logic [WORD_W-1:0] word;
        slot_t             second;
    } dec_state_t;

    dec_state_t dec_d, dec_q;

    opc_entry_t                 wr_entry;
    lookup_req_t [NPORT-1:0]    lk_req;
    lookup_rsp_t [NPORT-1:0]    lk_rsp;
    issue_mode_e                mode;
    slot_t                      split_first;
    slot_t                      split_second;
    slot_t                      slot_cur;
    logic                       slot_v;
    logic [ST_NUM-1:0]          stat_inc;
    logic [ST_NUM-1:0][CNT_W-1:0] stat_cnt;

    assign wr_entry = '{valid:     tbl_wr_valid,
                        is_long:   tbl_wr_long,
                        cond_only: tbl_wr_cond,
                        mask:      tbl_wr_mask,
                        opcode:    tbl_wr_opcode};

    opc_table #(.NPORT(NPORT)) i_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr_en),
        .wr_idx   (tbl_wr_idx),
        .wr_entry (wr_entry),
        .req      (lk_req),
        .rsp      (lk_rsp)
    );

    word_split i_split (
        .word   (dec_q.word),
        .rsp_l  (lk_rsp[0]),
        .rsp_r  (lk_rsp[1]),
        .req_l  (lk_req[0]),
        .req_r  (lk_req[1]),
        .mode   (mode),
        .first  (split_first),
        .second (split_second)
    );

    always_comb begin
        logic stop;
        dec_d    = dec_q;
        stat_inc = '0;
        slot_cur = '0;
        slot_v   = 1'b0;
        stop     = 1'b0;
        unique case (dec_q.phase)
            PH_IDLE: begin
                if (word_valid) begin
                    dec_d.word           = word_data;
                    dec_d.phase          = PH_FIRST;
                    stat_inc[ST_CYCLES]  = 1'b1;
                    unique case (fmt_e'(word_data[WORD_W-1 -: 2]))
                        FMT_LONG:   stat_inc[ST_LONG] = 1'b1;
                        FMT_RFIRST: stat_inc[ST_RL]   = 1'b1;
                        FMT_LFIRST: stat_inc[ST_LR]   = 1'b1;
                        FMT_PAR:    stat_inc[ST_PAR]  = 1'b1;
                        default:    stat_inc[ST_PAR]  = 1'b0;
                    endcase
                end
            end
            PH_FIRST: begin
                slot_cur         = split_first;
                slot_v           = 1'b1;
                stat_inc[ST_ILL] = split_first.illegal;
                stop             = ex_exception || split_first.illegal;
                dec_d.phase      = PH_IDLE;
                dec_d.second     = split_second;
                unique case (mode)
                    MODE_LONG: begin
                        dec_d.phase = PH_IDLE;
                    end
                    MODE_SEQ: begin
                        if (!stop && !ex_pc_changed) begin
                            dec_d.phase         = PH_SECOND;
                            stat_inc[ST_CYCLES] = 1'b1;
                        end
                        stat_inc[ST_BRSKIP] = ex_pc_changed && !stop;
                    end
                    MODE_PAR: begin
                        if (!stop) begin
                            dec_d.phase = PH_SECOND;
                        end
                    end
                    MODE_COND: begin
                        if (!stop) begin
                            if (ex_cond_true) begin
                                dec_d.phase        = PH_SECOND;
                                stat_inc[ST_CTRUE] = 1'b1;
                            end else begin
                                stat_inc[ST_CFALSE] = 1'b1;
                            end
                        end
                    end
                    default: begin
                        dec_d.phase = PH_IDLE;
                    end
                endcase
            end
            PH_SECOND: begin
                slot_cur         = dec_q.second;
                slot_v           = 1'b1;
                stat_inc[ST_ILL] = dec_q.second.illegal;
                dec_d.phase      = PH_IDLE;
            end
            default: begin
                dec_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    stat_bank #(.NUM(ST_NUM), .W(CNT_W)) i_stats (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (stat_inc),
        .cnt   (stat_cnt)
    );

    assign word_ready     = (dec_q.phase == PH_IDLE);
    assign slot_valid     = slot_v;
    assign slot_insn      = slot_cur.op;
    assign slot_tag       = slot_cur.tag;
    assign slot_right     = slot_cur.right;
    assign slot_illegal   = slot_cur.illegal;
    assign cnt_cycles     = stat_cnt[ST_CYCLES];
    assign cnt_long       = stat_cnt[ST_LONG];
    assign cnt_seq_lr     = stat_cnt[ST_LR];
    assign cnt_seq_rl     = stat_cnt[ST_RL];
    assign cnt_par        = stat_cnt[ST_PAR];
    assign cnt_cond_true  = stat_cnt[ST_CTRUE];
    assign cnt_cond_false = stat_cnt[ST_CFALSE];
    assign cnt_br_skip    = stat_cnt[ST_BRSKIP];
    assign cnt_illegal    = stat_cnt[ST_ILL];

endmodule

// File: rtl/issue_decoder_chk.sv
module issue_decoder_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             word_valid,
    input logic             word_ready,
    input logic             ex_exception,
    input logic             slot_valid,
    input logic [2:0]       slot_tag,
    input logic             slot_illegal,
    input logic [CNT_W-1:0] cnt_cycles
);

    assert_tag_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid |-> slot_tag != 3'd0);

    assert_long_alone_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && slot_tag == 3'd1) |=> !slot_valid);

    assert_illegal_ends_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && slot_illegal) |=> !slot_valid);

    assert_exception_ends_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && ex_exception) |=> !slot_valid);

    assert_par_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && slot_tag == 3'd5) |-> $past(slot_valid && slot_tag == 3'd4));

    assert_cond_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && slot_tag == 3'd7) |-> $past(slot_valid && slot_tag == 3'd6));

    assert_cycles_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_cycles - $past(cnt_cycles)) <= CNT_W'(1));

    assert_busy_while_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid |-> !word_ready);

    assert_slot_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_ready) |=> slot_valid);

endmodule

bind issue_decoder issue_decoder_chk #(.CNT_W(CNT_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_valid   (word_valid),
    .word_ready   (word_ready),
    .ex_exception (ex_exception),
    .slot_valid   (slot_valid),
    .slot_tag     (slot_tag),
    .slot_illegal (slot_illegal),
    .cnt_cycles   (cnt_cycles)
);

// File: tb/test_issue_decoder.sv
`timescale 1ns/1ps
module test_issue_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_wr_en = 1'b0;
    logic [5:0]  tbl_wr_idx = '0;
    logic        tbl_wr_valid = 1'b0;
    logic        tbl_wr_long = 1'b0;
    logic        tbl_wr_cond = 1'b0;
    logic [29:0] tbl_wr_mask = '0;
    logic [29:0] tbl_wr_opcode = '0;
    logic        word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic        word_ready;
    logic        ex_pc_changed = 1'b0;
    logic        ex_exception = 1'b0;
    logic        ex_cond_true = 1'b0;
    logic        slot_valid;
    logic [29:0] slot_insn;
    logic [2:0]  slot_tag;
    logic        slot_right;
    logic        slot_illegal;
    logic [31:0] cnt_cycles, cnt_long, cnt_seq_lr, cnt_seq_rl, cnt_par;
    logic [31:0] cnt_cond_true, cnt_cond_false, cnt_br_skip, cnt_illegal;

    always #4 clk = ~clk;

    issue_decoder i_issue_decoder (
        .clk(clk), .rst_n(rst_n),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_valid(tbl_wr_valid),
        .tbl_wr_long(tbl_wr_long), .tbl_wr_cond(tbl_wr_cond),
        .tbl_wr_mask(tbl_wr_mask), .tbl_wr_opcode(tbl_wr_opcode),
        .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
        .ex_pc_changed(ex_pc_changed), .ex_exception(ex_exception), .ex_cond_true(ex_cond_true),
        .slot_valid(slot_valid), .slot_insn(slot_insn), .slot_tag(slot_tag),
        .slot_right(slot_right), .slot_illegal(slot_illegal),
        .cnt_cycles(cnt_cycles), .cnt_long(cnt_long), .cnt_seq_lr(cnt_seq_lr),
        .cnt_seq_rl(cnt_seq_rl), .cnt_par(cnt_par), .cnt_cond_true(cnt_cond_true),
        .cnt_cond_false(cnt_cond_false), .cnt_br_skip(cnt_br_skip), .cnt_illegal(cnt_illegal)
    );

    // tag values from R1
    localparam logic [2:0] T_LONG = 3'd1, T_LEFT = 3'd2, T_RIGHT = 3'd3, T_PL = 3'd4,
                           T_PR = 3'd5, T_CT = 3'd6, T_CE = 3'd7;

    typedef struct packed {
        logic [29:0] op;
        logic [2:0]  tag;
        logic        right;
        logic        ill;
    } exp_slot_t;

    exp_slot_t exp_q[$];
    string     req_q[$];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference table
    bit          m_valid [64];
    bit          m_long  [64];
    bit          m_cond  [64];
    logic [29:0] m_mask  [64];
    logic [29:0] m_opc   [64];

    int e_cyc = 0, e_long = 0, e_lr = 0, e_rl = 0, e_par = 0;
    int e_ct = 0, e_cf = 0, e_br = 0, e_ill = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit m_hit(input logic [29:0] op, input bit lng);
        int idx;
        idx = lng ? int'(op[29:24]) : int'(op[14:9]);
        return m_valid[idx] && (m_long[idx] == lng) && ((op & m_mask[idx]) == m_opc[idx]);
    endfunction

    function automatic bit m_is_cond(input logic [29:0] op);
        return m_cond[int'(op[14:9])];
    endfunction

    task automatic push(input logic [29:0] op, input logic [2:0] tag, input bit right,
                        input bit ill, input string req);
        exp_slot_t e;
        e.op = op; e.tag = tag; e.right = right; e.ill = ill;
        exp_q.push_back(e);
        req_q.push_back(req);
        if (ill) e_ill++;
    endtask

    // monitor: compare presented slots against the scoreboard
    always @(negedge clk) begin
        if (rst_n && slot_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected slot", {slot_tag, slot_insn[28:0]}, 32'h0);
            end else begin
                exp_slot_t e;
                string     r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                chk(slot_insn == e.op && slot_tag == e.tag && slot_right == e.right
                    && slot_illegal == e.ill, r,
                    {slot_illegal, slot_right, slot_tag[1:0], slot_insn[27:0]},
                    {e.ill, e.right, e.tag[1:0], e.op[27:0]});
                if (slot_tag != e.tag) chk(1'b0, r, 32'(slot_tag), 32'(e.tag));
            end
        end
    end

    task automatic tbl_write(input int idx, input bit lng, input bit cnd,
                             input logic [29:0] mask, input logic [29:0] opc);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_idx = 6'(idx); tbl_wr_valid = 1'b1;
        tbl_wr_long = lng; tbl_wr_cond = cnd; tbl_wr_mask = mask; tbl_wr_opcode = opc;
        m_valid[idx] = 1'b1; m_long[idx] = lng; m_cond[idx] = cnd;
        m_mask[idx] = mask; m_opc[idx] = opc;
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    task automatic check_counters(input string label);
        chk(cnt_cycles == 32'(e_cyc), {"R7 cycles ", label}, cnt_cycles, 32'(e_cyc));
        chk(cnt_long == 32'(e_long), {"R9 long ", label}, cnt_long, 32'(e_long));
        chk(cnt_seq_lr == 32'(e_lr), {"R9 left-first ", label}, cnt_seq_lr, 32'(e_lr));
        chk(cnt_seq_rl == 32'(e_rl), {"R9 right-first ", label}, cnt_seq_rl, 32'(e_rl));
        chk(cnt_par == 32'(e_par), {"R9 parallel ", label}, cnt_par, 32'(e_par));
        chk(cnt_cond_true == 32'(e_ct), {"R6 cond true ", label}, cnt_cond_true, 32'(e_ct));
        chk(cnt_cond_false == 32'(e_cf), {"R6 cond false ", label}, cnt_cond_false, 32'(e_cf));
        chk(cnt_br_skip == 32'(e_br), {"R4 branch skip ", label}, cnt_br_skip, 32'(e_br));
        chk(cnt_illegal == 32'(e_ill), {"R3 illegal ", label}, cnt_illegal, 32'(e_ill));
    endtask

    // reference model: predict the slots of one word
    task automatic predict(input logic [31:0] w, input bit pc, input bit exc, input bit cnd);
        logic [29:0] lop, rop, f, s;
        bit fi, lh, rh, tr;
        lop = {15'b0, w[29:15]};
        rop = {15'b0, w[14:0]};
        e_cyc++;
        case (w[31:30])
            2'b00: begin
                e_long++;
                push(w[29:0], T_LONG, 1'b0, !m_hit(w[29:0], 1'b1), "R1 R2 long op");
            end
            2'b01, 2'b10: begin
                tr = (w[31:30] == 2'b01);
                if (tr) e_rl++; else e_lr++;
                f  = tr ? rop : lop;
                s  = tr ? lop : rop;
                fi = !m_hit(f, 1'b0);
                push(f, tr ? T_RIGHT : T_LEFT, tr, fi, "R1 R2 sequential first");
                if (!(fi || exc || pc)) begin
                    push(s, tr ? T_LEFT : T_RIGHT, !tr, !m_hit(s, 1'b0), "R4 sequential second");
                    e_cyc++;
                end else if (pc && !(fi || exc)) begin
                    e_br++;
                end
            end
            default: begin
                e_par++;
                lh = m_hit(lop, 1'b0);
                rh = m_hit(rop, 1'b0);
                if ((lh && m_is_cond(lop)) || (rh && m_is_cond(rop))) begin
                    tr = !(lh && m_is_cond(lop));
                    f  = tr ? rop : lop;
                    s  = tr ? lop : rop;
                    push(f, T_CT, tr, 1'b0, "R6 condition test");
                    if (!exc) begin
                        if (cnd) begin
                            e_ct++;
                            push(s, T_CE, !tr, !m_hit(s, 1'b0), "R6 conditional execute");
                        end else begin
                            e_cf++;
                        end
                    end
                end else begin
                    push(lop, T_PL, 1'b0, !lh, "R5 parallel left");
                    if (!(exc || !lh)) push(rop, T_PR, 1'b1, !rh, "R5 parallel right");
                end
            end
        endcase
    endtask

    task automatic run_word(input logic [31:0] w, input bit pc, input bit exc, input bit cnd,
                            input bit inject, input logic [31:0] inj_w, input string label);
        @(negedge clk);
        while (!word_ready) @(negedge clk);
        ex_pc_changed = pc; ex_exception = exc; ex_cond_true = cnd;
        predict(w, pc, exc, cnd);
        word_data = w; word_valid = 1'b1;
        @(negedge clk);
        chk(slot_valid == 1'b1, {"R11 first slot timing ", label}, 32'(slot_valid), 32'h1);
        chk(word_ready == 1'b0, {"R8 busy after accept ", label}, 32'(word_ready), 32'h0);
        if (inject) begin
            word_data = inj_w;
            word_valid = 1'b1;
            @(negedge clk);
        end
        word_valid = 1'b0;
        while (!word_ready) @(negedge clk);
        #1;
        chk(exp_q.size() == 0, {"R4 all expected slots issued ", label}, 32'(exp_q.size()), 32'h0);
        check_counters(label);
        ex_pc_changed = 1'b0; ex_exception = 1'b0; ex_cond_true = 1'b0;
    endtask

    // short ops named by their table rows
    localparam logic [14:0] OP_A  = 15'h0A11; // row 5, plain
    localparam logic [14:0] OP_C  = 15'h0C22; // row 6, condition test
    localparam logic [14:0] OP_E  = 15'h0E33; // row 7, plain
    localparam logic [14:0] OP_M1 = 15'h1004; // row 8, mask matches
    localparam logic [14:0] OP_M0 = 15'h1003; // row 8, mask mismatch
    localparam logic [14:0] OP_X  = 15'h1233; // row 9, never written

    function automatic logic [31:0] mk(input logic [1:0] fmt, input logic [14:0] l, input logic [14:0] r);
        return {fmt, l, r};
    endfunction

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(word_ready == 1'b1, "R10 ready after reset", 32'(word_ready), 32'h1);
        chk(slot_valid == 1'b0, "R10 no slot after reset", 32'(slot_valid), 32'h0);
        check_counters("R10 reset");

        // R10 empty table: every op illegal, R3 partner dropped
        run_word(mk(2'b10, OP_A, OP_E), 1'b0, 1'b0, 1'b0, 1'b0, '0, "R10 empty table");

        tbl_write(5, 1'b0, 1'b0, 30'h7E00, 30'h0A00);
        tbl_write(6, 1'b0, 1'b1, 30'h7E00, 30'h0C00);
        tbl_write(7, 1'b0, 1'b0, 30'h7E00, 30'h0E00);
        tbl_write(8, 1'b0, 1'b0, 30'h7E0F, 30'h1004);
        tbl_write(2, 1'b1, 1'b0, 30'h3F000000, 30'h02000000);

        run_word({2'b00, 30'h02ABCDEF}, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R2 long legal");
        run_word({2'b00, 30'h05000A00}, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R2 size mismatch");
        run_word(mk(2'b01, OP_A, OP_E), 1'b0, 1'b0, 1'b0, 1'b0, '0, "R1 right first");
        run_word(mk(2'b10, OP_A, OP_E), 1'b0, 1'b0, 1'b0, 1'b0, '0, "R1 left first");
        run_word(mk(2'b10, OP_A, OP_E), 1'b1, 1'b0, 1'b0, 1'b0, '0, "R4 pc changed");
        run_word(mk(2'b01, OP_A, OP_E), 1'b0, 1'b1, 1'b0, 1'b0, '0, "R4 exception");
        run_word(mk(2'b10, OP_X, OP_E), 1'b0, 1'b0, 1'b0, 1'b0, '0, "R3 illegal first");
        run_word(mk(2'b10, OP_M1, OP_M0), 1'b0, 1'b0, 1'b0, 1'b0, '0, "R2 mask compare");
        run_word(mk(2'b11, OP_A, OP_E), 1'b1, 1'b0, 1'b0, 1'b0, '0, "R5 parallel pc ignored");
        run_word(mk(2'b11, OP_A, OP_E), 1'b0, 1'b1, 1'b0, 1'b0, '0, "R5 parallel exception");
        run_word(mk(2'b11, OP_X, OP_E), 1'b0, 1'b0, 1'b0, 1'b0, '0, "R5 parallel illegal left");
        run_word(mk(2'b11, OP_C, OP_E), 1'b0, 1'b0, 1'b1, 1'b0, '0, "R6 left test true");
        run_word(mk(2'b11, OP_C, OP_E), 1'b0, 1'b0, 1'b0, 1'b0, '0, "R6 left test false");
        run_word(mk(2'b11, OP_A, OP_C), 1'b0, 1'b0, 1'b1, 1'b0, '0, "R6 right test true");
        run_word(mk(2'b11, OP_C, OP_C), 1'b0, 1'b0, 1'b1, 1'b0, '0, "R6 left priority");
        run_word(mk(2'b11, OP_C, OP_X), 1'b0, 1'b0, 1'b1, 1'b0, '0, "R6 illegal partner");
        run_word(mk(2'b11, OP_C, OP_E), 1'b0, 1'b1, 1'b1, 1'b0, '0, "R6 test exception");
        run_word(mk(2'b10, OP_A, OP_E), 1'b0, 1'b0, 1'b0, 1'b1, {2'b00, 30'h02000001}, "R8 busy ignore seq");
        run_word({2'b00, 30'h02000002}, 1'b0, 1'b0, 1'b0, 1'b1, mk(2'b11, OP_A, OP_E), "R8 busy ignore long");

        // mixed stream
        for (int n = 0; n < 300; n++) begin
            logic [14:0] pool [6];
            logic [31:0] w;
            pool[0] = OP_A; pool[1] = OP_C; pool[2] = OP_E;
            pool[3] = OP_M1; pool[4] = OP_M0; pool[5] = OP_X;
            w = mk(2'($urandom_range(0, 3)), pool[$urandom_range(0, 5)], pool[$urandom_range(0, 5)]);
            if (w[31:30] == 2'b00) begin
                w[29:24] = ($urandom_range(0, 1) == 1) ? 6'h02 : 6'(n % 8);
            end
            run_word(w, 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 4) == 0),
                     1'($urandom_range(0, 1)), 1'($urandom_range(0, 5) == 0),
                     mk(2'b11, OP_A, OP_E), "R1 R4 R5 R6 mixed");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule